// File: doc/BRIEF.md
# Multiplexed-Bus External Memory Controller

This block lets a processor reach external SRAM or flash through a narrow bus on which the low address byte and the 8-bit data share the same lines. The processor sees a small register port. It can set a base address and two offsets, choose a word length and a strobe timing, write a data word, and collect a read word. Every processor word of 8, 16 or 24 bits is split into one, two or three byte cycles. Each byte cycle puts out the full byte address, marks the address phase with a latch-enable pulse, and then drives a read or a write strobe. Both strobes are active low.

Effective addresses are the base register plus one of the offsets, taken modulo the 4-Mbyte space. A write starts when the processor writes the write-data register. A configuration bit chooses how a read starts. In one mode it starts when an offset register is written. In the other it starts when the read-data register is read, and that read returns the result of the access before it. Software learns that an access is complete by polling the status register or from an interrupt.

Top module: `xmem_ctrl`

## Requirements
- R1: After reset, busy, done, error and irq are 0, ale is 0, rdN and wrN are 1, adOe is 0, and all registers read 0. Register map: 0 write data, 1 read data, 2 offset A, 3 offset B, 4 base, 5 control, 6 status.
- R2: During the address phase, ale is 1, adOe is 1, adOut carries address bits 7..0 and hiAddr carries bits 21..8. The effective address is (base + offset) mod 2^22.
- R3: Control bits [1:0] set the word length: 0 gives one byte, 1 gives two bytes, and 2 or 3 gives three bytes. Bytes move least significant first, at consecutive byte addresses that wrap modulo 2^22.
- R4: Writing register 0 while idle stores the word and starts a write at base + offset A. Each data byte is on adOut with adOe at 1 while wrN is low.
- R5: When control bit 4 is 0, reading register 1 returns the previous result and starts a read at base + offset B if control bit 5 is 1, or at base + offset A otherwise.
- R6: When control bit 4 is 1, writing register 2 or 3 stores the offset and starts a read at base + the new value, and reading register 1 starts nothing.
- R7: A read byte is sampled on adIn at the end of its last strobe cycle and placed at its byte lane. Lanes above the word length read as zero.
- R8: With control bits [3:2] = t, each byte takes one ale cycle, then t+1 cycles with the strobe low, then one gap cycle with both strobes high.
- R9: rdN and wrN are never low together, and adOe is 0 whenever rdN is low.
- R10: Status bit 0 (busy) is 1 from the cycle after the trigger until the gap cycle of the last byte, which takes words × (t+3) cycles in total. Status bit 1 (done) is set when the access completes.
- R11: While busy, any register write other than to status is ignored, and so is a read trigger. Either one sets status bit 2 (error).
- R12: Writing status clears done and error. If an access completes in the same cycle, done stays set.
- R13: irq equals control bit 6 AND done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWe | input | 1 | Register write strobe |
| regRe | input | 1 | Register read strobe (side effect only on register 1) |
| regAddr | input | 3 | Register select |
| regWdata | input | 24 | Register write data |
| regRdata | output | 24 | Register read data (combinational) |
| irq | output | 1 | Completion interrupt |
| hiAddr | output | 14 | Dedicated address lines 21..8 |
| adOut | output | 8 | Shared address/data lines, outgoing value |
| adIn | input | 8 | Shared address/data lines, incoming value |
| adOe | output | 1 | Drive enable for the shared lines |
| ale | output | 1 | Address latch enable |
| rdN | output | 1 | Read strobe, active low |
| wrN | output | 1 | Write strobe, active low |

## Verification
A status-register write that clears the flags and the completion of an access can land on the same clock edge. If they do, the completion must not be lost. The bench times a clear to hit the edge on which the gap cycle of the last byte ends. It does this by counting cycles from a one-byte trigger with the shortest timing. It then requires done to read 1 and error to read 0. A stray write made while busy is also checked against the registers it was aimed at, which must be unchanged, and against the error flag.

// File: rtl/xmem_pkg.sv
package xmem_pkg;
  localparam int REG_AW = 3;

  localparam logic [REG_AW-1:0] RA_WDATA = 3'd0;
  localparam logic [REG_AW-1:0] RA_RDATA = 3'd1;
  localparam logic [REG_AW-1:0] RA_OFFA  = 3'd2;
  localparam logic [REG_AW-1:0] RA_OFFB  = 3'd3;
  localparam logic [REG_AW-1:0] RA_BASE  = 3'd4;
  localparam logic [REG_AW-1:0] RA_CTRL  = 3'd5;
  localparam logic [REG_AW-1:0] RA_STAT  = 3'd6;

  typedef enum logic [1:0] {PH_IDLE, PH_ADDR, PH_STRB, PH_GAP} busPhase_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic cfgWrite;
    logic startAcc;
    logic startRead;
    logic useOffB;
    logic offFromBus;
    logic capByte;
    logic nextByte;
    logic finish;
    logic errSet;
    logic clrFlags;
  } dpStrobe_t;
endpackage

// File: rtl/xmem_control.sv
module xmem_control
  import xmem_pkg::*;
#(
  parameter int MAX_BYTES = 3,
  parameter int WAIT_W    = 2,
  localparam int IDX_W    = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic              regRe,
  input  logic [REG_AW-1:0] regAddr,
  input  logic              trigOnOffset,
  input  logic              offSelCfg,
  input  logic [1:0]        wordLen,
  input  logic [WAIT_W-1:0] waitSel,
  output dpStrobe_t         strb,
  output busPhase_t         phase,
  output logic              isRead,
  output logic [IDX_W-1:0]  byteIdx,
  output logic              busy
);
  logic [WAIT_W-1:0] waitCnt;
  logic [IDX_W-1:0]  lastIdx;
  logic              wrTrig, rdTrigOff, rdTrigRd;

  always_comb begin
    lastIdx = (int'(wordLen) >= MAX_BYTES - 1) ? IDX_W'(MAX_BYTES - 1) : IDX_W'(wordLen);
  end

  assign busy = (phase != PH_IDLE);

  always_comb begin
    wrTrig    = regWe && (regAddr == RA_WDATA);
    rdTrigOff = regWe && trigOnOffset && ((regAddr == RA_OFFA) || (regAddr == RA_OFFB));
    rdTrigRd  = regRe && !trigOnOffset && (regAddr == RA_RDATA);
    strb = '0;
    if (busy) begin
      strb.errSet = (regWe && (regAddr != RA_STAT)) || rdTrigRd;
    end else begin
      strb.cfgWrite   = regWe;
      strb.startAcc   = wrTrig || rdTrigOff || rdTrigRd;
      strb.startRead  = rdTrigOff || rdTrigRd;
      strb.offFromBus = rdTrigOff;
      strb.useOffB    = rdTrigOff ? (regAddr == RA_OFFB) : (rdTrigRd && offSelCfg);
    end
    strb.clrFlags = regWe && (regAddr == RA_STAT);
    strb.capByte  = (phase == PH_STRB) && (waitCnt == waitSel) && isRead;
    strb.nextByte = (phase == PH_GAP) && (byteIdx != lastIdx);
    strb.finish   = (phase == PH_GAP) && (byteIdx == lastIdx);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      waitCnt <= '0;
      byteIdx <= '0;
      isRead  <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: if (strb.startAcc) begin
          phase   <= PH_ADDR;
          byteIdx <= '0;
          isRead  <= strb.startRead;
        end
        PH_ADDR: begin
          phase   <= PH_STRB;
          waitCnt <= '0;
        end
        PH_STRB: begin
          if (waitCnt == waitSel) phase <= PH_GAP;
          else                    waitCnt <= waitCnt + 1'b1;
        end
        PH_GAP: begin
          if (strb.finish) phase <= PH_IDLE;
          else begin
            phase   <= PH_ADDR;
            byteIdx <= byteIdx + 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !strb.finish) |=> busy);

  // R8
  strobe_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_STRB && waitCnt != waitSel) |=> (phase == PH_STRB));

  // R11
  busy_no_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !strb.startAcc);
endmodule

// File: rtl/xmem_datapath.sv
module xmem_datapath
  import xmem_pkg::*;
#(
  parameter int ADDR_W    = 22,
  parameter int BYTE_W    = 8,
  parameter int MAX_BYTES = 3,
  parameter int WAIT_W    = 2,
  localparam int WORD_W   = BYTE_W * MAX_BYTES,
  localparam int HI_W     = ADDR_W - BYTE_W,
  localparam int IDX_W    = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1,
  localparam int CTRL_W   = WAIT_W + 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [WORD_W-1:0] regWdata,
  output logic [WORD_W-1:0] regRdata,
  input  dpStrobe_t         strb,
  input  busPhase_t         phase,
  input  logic              isRead,
  input  logic [IDX_W-1:0]  byteIdx,
  input  logic              busy,
  output logic              trigOnOffset,
  output logic              offSelCfg,
  output logic [1:0]        wordLen,
  output logic [WAIT_W-1:0] waitSel,
  output logic              irq,
  output logic [HI_W-1:0]   hiAddr,
  output logic [BYTE_W-1:0] adOut,
  input  logic [BYTE_W-1:0] adIn,
  output logic              adOe,
  output logic              ale,
  output logic              rdN,
  output logic              wrN
);
  logic [WORD_W-1:0] wdataReg, rdBuf;
  logic [ADDR_W-1:0] offA, offB, baseReg, curAddr, offPick, startAddr;
  logic [CTRL_W-1:0] ctrlReg;
  logic              doneFlag, errFlag, irqEn;
  logic [BYTE_W-1:0] wrByte;

  assign wordLen      = ctrlReg[1:0];
  assign waitSel      = ctrlReg[2 +: WAIT_W];
  assign trigOnOffset = ctrlReg[WAIT_W + 2];
  assign offSelCfg    = ctrlReg[WAIT_W + 3];
  assign irqEn        = ctrlReg[WAIT_W + 4];

  always_comb begin
    offPick   = strb.offFromBus ? ADDR_W'(regWdata) : (strb.useOffB ? offB : offA);
    startAddr = baseReg + offPick;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wdataReg <= '0;
      offA     <= '0;
      offB     <= '0;
      baseReg  <= '0;
      ctrlReg  <= '0;
    end else if (strb.cfgWrite) begin
      case (regAddr)
        RA_WDATA: wdataReg <= regWdata;
        RA_OFFA:  offA     <= ADDR_W'(regWdata);
        RA_OFFB:  offB     <= ADDR_W'(regWdata);
        RA_BASE:  baseReg  <= ADDR_W'(regWdata);
        RA_CTRL:  ctrlReg  <= CTRL_W'(regWdata);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr  <= '0;
      rdBuf    <= '0;
      doneFlag <= 1'b0;
      errFlag  <= 1'b0;
    end else begin
      if (strb.startAcc)      curAddr <= startAddr;
      else if (strb.nextByte) curAddr <= curAddr + 1'b1;

      if (strb.startRead)    rdBuf <= '0;
      else if (strb.capByte) rdBuf[int'(byteIdx)*BYTE_W +: BYTE_W] <= adIn;

      if (strb.finish)                          doneFlag <= 1'b1;
      else if (strb.clrFlags || strb.startAcc)  doneFlag <= 1'b0;

      if (strb.errSet)        errFlag <= 1'b1;
      else if (strb.clrFlags) errFlag <= 1'b0;
    end
  end

  always_comb begin
    wrByte = wdataReg[int'(byteIdx)*BYTE_W +: BYTE_W];
    ale    = (phase == PH_ADDR);
    adOut  = ale ? curAddr[BYTE_W-1:0] : wrByte;
    adOe   = ale || ((phase == PH_STRB) && !isRead);
    rdN    = !((phase == PH_STRB) && isRead);
    wrN    = !((phase == PH_STRB) && !isRead);
    hiAddr = curAddr[ADDR_W-1:BYTE_W];
    irq    = irqEn && doneFlag;
  end

  always_comb begin
    case (regAddr)
      RA_WDATA: regRdata = wdataReg;
      RA_RDATA: regRdata = rdBuf;
      RA_OFFA:  regRdata = WORD_W'(offA);
      RA_OFFB:  regRdata = WORD_W'(offB);
      RA_BASE:  regRdata = WORD_W'(baseReg);
      RA_CTRL:  regRdata = WORD_W'(ctrlReg);
      RA_STAT:  regRdata = WORD_W'({errFlag, doneFlag, busy});
      default:  regRdata = '0;
    endcase
  end

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdN || wrN) && !(!rdN && adOe));

  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.nextByte |=> (curAddr == ADDR_W'($past(curAddr) + 1'b1)));

  // R8
  ale_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    ale |=> (!ale && (!rdN || !wrN)));

  // R10
  done_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.finish |=> (doneFlag && !busy));

  // R11
  busy_regs_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> ($stable(offA) && $stable(offB) && $stable(baseReg) &&
              $stable(ctrlReg) && $stable(wdataReg)));

  // R11
  err_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.errSet |=> errFlag);
endmodule

// File: rtl/xmem_ctrl.sv
module xmem_ctrl
  import xmem_pkg::*;
#(
  parameter int ADDR_W    = 22,
  parameter int BYTE_W    = 8,
  parameter int MAX_BYTES = 3,
  parameter int WAIT_W    = 2,
  localparam int WORD_W   = BYTE_W * MAX_BYTES,
  localparam int HI_W     = ADDR_W - BYTE_W,
  localparam int IDX_W    = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic              regRe,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [WORD_W-1:0] regWdata,
  output logic [WORD_W-1:0] regRdata,
  output logic              irq,
  output logic [HI_W-1:0]   hiAddr,
  output logic [BYTE_W-1:0] adOut,
  input  logic [BYTE_W-1:0] adIn,
  output logic              adOe,
  output logic              ale,
  output logic              rdN,
  output logic              wrN
);
  dpStrobe_t         strb;
  busPhase_t         phase;
  logic              isRead, busy, trigOnOffset, offSelCfg;
  logic [IDX_W-1:0]  byteIdx;
  logic [1:0]        wordLen;
  logic [WAIT_W-1:0] waitSel;

  xmem_control #(.MAX_BYTES(MAX_BYTES), .WAIT_W(WAIT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regRe(regRe), .regAddr(regAddr),
    .trigOnOffset(trigOnOffset), .offSelCfg(offSelCfg), .wordLen(wordLen),
    .waitSel(waitSel), .strb(strb), .phase(phase), .isRead(isRead),
    .byteIdx(byteIdx), .busy(busy)
  );

  xmem_datapath #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .MAX_BYTES(MAX_BYTES),
                  .WAIT_W(WAIT_W)) dp_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .strb(strb), .phase(phase), .isRead(isRead),
    .byteIdx(byteIdx), .busy(busy), .trigOnOffset(trigOnOffset),
    .offSelCfg(offSelCfg), .wordLen(wordLen), .waitSel(waitSel), .irq(irq),
    .hiAddr(hiAddr), .adOut(adOut), .adIn(adIn), .adOe(adOe), .ale(ale),
    .rdN(rdN), .wrN(wrN)
  );
endmodule

// File: tb/xmem_ctrl_tb.sv
module xmem_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0, regRe = 1'b0;
  logic [2:0]  regAddr = 3'd0;
  logic [23:0] regWdata = '0;
  logic [23:0] regRdata;
  logic        irq, adOe, ale, rdN, wrN;
  logic [13:0] hiAddr;
  logic [7:0]  adOut, adIn;

  int compared = 0, mismatched = 0;

  always #10 clk = ~clk;

  xmem_ctrl dut_i (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regRe(regRe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .irq(irq), .hiAddr(hiAddr),
    .adOut(adOut), .adIn(adIn), .adOe(adOe), .ale(ale), .rdN(rdN), .wrN(wrN)
  );

  // behavioural memory, low 10 address bits decoded
  logic [7:0]  mem [1024];
  logic [21:0] latchA = '0;
  logic [21:0] logA [4];
  logic [7:0]  logD [4];
  int          logN = 0;
  int          rdRun = 0, wrRun = 0, lastRdW = 0, lastWrW = 0;
  logic        prevRdN = 1'b1, prevWrN = 1'b1;

  function automatic logic [7:0] initByte(input int a);
    return 8'((a * 7 + 3) & 255);
  endfunction

  initial for (int i = 0; i < 1024; i++) mem[i] = initByte(i);

  assign adIn = (!rdN) ? mem[latchA[9:0]] : 8'h00;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      if (ale) begin
        latchA = {hiAddr, adOut};
        if (!adOe) chk("R2 adOe in address phase", 0, 1);
      end
      if (!rdN && !wrN) chk("R9 both strobes low", 1, 0);
      if (!rdN && adOe) chk("R9 drive during read", 1, 0);
      if (!wrN && prevWrN) begin
        mem[latchA[9:0]] = adOut;
        if (logN < 4) begin logA[logN] = latchA; logD[logN] = adOut; end
        logN++;
      end
      if (!rdN) rdRun++; else if (!prevRdN) begin lastRdW = rdRun; rdRun = 0; end
      if (!wrN) wrRun++; else if (!prevWrN) begin lastWrW = wrRun; wrRun = 0; end
      prevRdN = rdN;
      prevWrN = wrN;
    end
  end

  task automatic doWrite(input logic [2:0] a, input logic [23:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic doRead(input logic [2:0] a, output logic [23:0] d);
    @(negedge clk);
    regRe = 1'b1; regAddr = a;
    #1 d = regRdata;
    @(negedge clk);
    regRe = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [23:0] d);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic waitIdle(output int n);
    logic [23:0] s;
    n = 0;
    peek(3'd6, s);
    while (s[0] && n < 2000) begin
      n++;
      @(negedge clk);
      peek(3'd6, s);
    end
  endtask

  typedef struct packed {
    logic [1:0]  len;
    logic [1:0]  ws;
    logic [21:0] base;
    logic [21:0] off;
    logic [23:0] data;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{2'd0, 2'd0, 22'h000100, 22'h000010, 24'hA5A5C3},
    '{2'd1, 2'd1, 22'h3FFFFE, 22'h000001, 24'h123456},
    '{2'd2, 2'd2, 22'h000200, 22'h000020, 24'hDEADBE},
    '{2'd3, 2'd3, 22'h000010, 22'h000005, 24'h0F1E2D},
    '{2'd2, 2'd0, 22'h2ABC00, 22'h0000FF, 24'h778899},
    '{2'd1, 2'd3, 22'h000080, 22'h00007E, 24'hCAFE01}
  };

  task automatic report;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [23:0] v;
    int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    peek(3'd6, v); chk("R1 status", 32'(v), 0);
    peek(3'd5, v); chk("R1 control", 32'(v), 0);
    peek(3'd4, v); chk("R1 base", 32'(v), 0);
    chk("R1 pins", {27'd0, irq, ale, rdN, wrN, adOe}, 32'b00110);

    // table of write then read-back vectors
    foreach (VECS[k]) begin
      automatic int nb = (VECS[k].len == 0) ? 1 : (VECS[k].len == 1) ? 2 : 3;
      automatic logic [23:0] mask = (nb == 1) ? 24'hFF : (nb == 2) ? 24'hFFFF : 24'hFFFFFF;
      automatic logic [21:0] ea = VECS[k].base + VECS[k].off;
      doWrite(3'd4, 24'(VECS[k].base));
      doWrite(3'd2, 24'(VECS[k].off));
      doWrite(3'd5, {20'd0, VECS[k].ws, VECS[k].len});
      logN = 0;
      doWrite(3'd0, VECS[k].data);
      waitIdle(n);
      chk("R10 busy length", n, nb * (VECS[k].ws + 3));
      chk("R8 write strobe width", lastWrW, VECS[k].ws + 1);
      chk("R3 byte count", logN, nb);
      for (int b = 0; b < nb; b++) begin
        chk("R2 byte address", 32'(logA[b]), 32'(22'(ea + 22'(b))));
        chk("R4 byte data", 32'(logD[b]), 32'(VECS[k].data[b*8 +: 8]));
      end
      doRead(3'd1, v);
      waitIdle(n);
      chk("R8 read strobe width", lastRdW, VECS[k].ws + 1);
      doRead(3'd1, v);
      chk("R7 R5 read-back", 32'(v), 32'(VECS[k].data & mask));
      waitIdle(n);
      peek(3'd6, v);
      chk("R10 done flag", 32'(v), 32'h2);
    end

    // R6 read started by writing an offset register
    doWrite(3'd4, 24'h000300);
    doWrite(3'd5, 24'h000012);
    doWrite(3'd3, 24'h000040);
    waitIdle(n);
    chk("R6 offset trigger length", n, 9);
    doRead(3'd1, v);
    chk("R6 read via offset B", 32'(v),
        32'({initByte(32'h342), initByte(32'h341), initByte(32'h340)}));
    peek(3'd6, v);
    chk("R6 data read starts nothing", 32'(v[0]), 0);
    peek(3'd3, v);
    chk("R6 offset stored", 32'(v), 32'h40);

    // R5 read on data read, offset B selected
    doWrite(3'd5, 24'h000021);
    doWrite(3'd3, 24'h000050);
    peek(3'd6, v);
    chk("R5 offset write starts nothing", 32'(v[0]), 0);
    doRead(3'd1, v);
    waitIdle(n);
    doRead(3'd1, v);
    chk("R5 read at base+offB", 32'(v), 32'({initByte(32'h351), initByte(32'h350)}));
    waitIdle(n);

    // R11 writes while busy are ignored; R13 interrupt
    doWrite(3'd4, 24'h000200);
    doWrite(3'd2, 24'h000010);
    doWrite(3'd5, 24'h00004E);
    doWrite(3'd0, 24'h00BEEF);
    doWrite(3'd2, 24'h000099);
    waitIdle(n);
    peek(3'd2, v);
    chk("R11 offset unchanged", 32'(v), 32'h10);
    peek(3'd6, v);
    chk("R11 error flag", 32'(v), 32'h6);
    chk("R13 irq with enable", 32'(irq), 1);

    // R12 clear on the same edge as completion: one byte, t=0 -> 3 cycles
    doWrite(3'd5, 24'h000040);
    doWrite(3'd0, 24'h000055);
    @(negedge clk);
    @(negedge clk);
    regWe = 1'b1; regAddr = 3'd6;
    @(negedge clk);
    regWe = 1'b0;
    peek(3'd6, v);
    chk("R12 completion beats clear", 32'(v), 32'h2);
    chk("R13 irq follows done", 32'(irq), 1);
    doWrite(3'd6, 24'h0);
    peek(3'd6, v);
    chk("R12 idle clear", 32'(v), 0);
    chk("R13 irq cleared", 32'(irq), 0);

    report();
  end
endmodule